// File: doc/BRIEF.md
# Core Power-Domain Sequencer

This block brings one processor core's power domain up or down in a fixed order. It receives a single-cycle power-up or power-down request and then drives the domain's control lines one at a time. The lines are two staged power-switch enables, output isolation, SRAM isolation, SRAM clock isolation, clock disable and an active-low core reset. It also drives the request that powers down the core's L1 memory. Between steps it waits for the power-switch and L1 acknowledges. Every wait has a cycle-counted bound, and a wait that runs out aborts the sequence.

The power-down sequence can be gated on the core's idle (wait-for-interrupt) indication. The block reports progress with a busy level and a one-cycle done or fail pulse. The analog switches, the memory and the core sit outside the block. They answer through acknowledge inputs that must be synchronous to the block clock.

Top module: `core_pwr_seq`

## Requirements
- R1: Out of reset, `dom_ctrl` reads 7'h32 and `l1_pdn_req` is 1, with `seq_busy`, `seq_done` and `seq_fail` all low. The bit encoding of `dom_ctrl` is: bit 6 SRAM isolation (active low), bit 5 SRAM clock isolation, bit 4 clock disable, bit 3 second power enable, bit 2 first power enable, bit 1 output isolation, bit 0 core reset (active low).
- R2: Power-up sets bit 2 first. At least SETTLE_CYC cycles later it sets bit 3. It then waits until both `pwr_ack` and `pwr_ack2` are high, and only after that touches any other line.
- R3: Once both power acks are seen, power-up clears bit 1. It then drops `l1_pdn_req` and waits for `l1_ack` to read 0.
- R4: Once `l1_ack` reads 0, power-up waits at least MEMRDY_CYC cycles. It then sets bit 6, clears bit 5, clears bit 4 and finally sets bit 0, in that order, and pulses done. The final word is 7'h4D with `l1_pdn_req` at 0.
- R5: Power-down sets bit 1, then sets bit 5, then clears bit 6, then raises `l1_pdn_req`, and waits for `l1_ack` to read 1.
- R6: After that L1 ack, power-down clears bit 0, sets bit 4, clears bit 2 and then clears bit 3. It then waits for both power acks to read 0 and pulses done, ending at 7'h32 with `l1_pdn_req` at 1.
- R7: Each wait samples its condition on the first TIMEOUT_CYC clock edges after the wait starts. If the condition is never seen, the block pulses fail, returns to idle and leaves every output line as it was.
- R8: If the awaited condition is seen on the last permitted edge, the sequence proceeds. The acknowledge takes priority over the expiring timeout.
- R9: A power-down requested with `off_wait_idle` set first waits, under the same bound, for `core_idle`. If the wait runs out, the block fails without changing any control line.
- R10: `seq_busy` is high from the cycle after a request is accepted. It falls in the cycle in which `seq_done` or `seq_fail` pulses. Each pulse lasts one cycle, and the two never pulse together.
- R11: A request that arrives while a sequence runs has no effect on that sequence. It does not start another one afterwards.
- R12: When `req_on` and `req_off` are both high in an idle cycle, power-up is performed.
- R13: After a fail, a new request runs its full sequence from the lines as they were left, and ends in its normal final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request pulse, sampled when idle |
| req_off | input | 1 | Power-down request pulse, sampled when idle |
| off_wait_idle | input | 1 | Qualifies `req_off`: wait for core idle first |
| core_idle | input | 1 | Core is idle in wait-for-interrupt |
| pwr_ack | input | 1 | Primary power-switch status |
| pwr_ack2 | input | 1 | Secondary power-switch status |
| l1_ack | input | 1 | L1 memory power-down acknowledge |
| dom_ctrl | output | 7 | Domain control word, encoding in R1 |
| l1_pdn_req | output | 1 | L1 memory power-down request |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse: sequence completed |
| seq_fail | output | 1 | One-cycle pulse: sequence aborted on timeout |

## Verification
The two functions that can land in the same cycle are an acknowledge arrival and the expiry of the wait bound. The bench sweeps the delay of the secondary power ack and of the L1 ack, in both directions, from zero to beyond the bound. At a delay of TIMEOUT_CYC-1 the ack is first seen on the very edge where the timer would expire, and the bench expects the sequence to complete. At one cycle more it expects fail, with the control word frozen at its arithmetically computed partial value.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int CTRL_W      = 7;
  localparam int BIT_RST_N   = 0;
  localparam int BIT_OUT_ISO = 1;
  localparam int BIT_EN1     = 2;
  localparam int BIT_EN2     = 3;
  localparam int BIT_CLK_DIS = 4;
  localparam int BIT_SCK_ISO = 5;
  localparam int BIT_SRAM_N  = 6;

  // fully off: isolated, clocks gated, reset held, switches open
  localparam logic [CTRL_W-1:0] CTRL_ALL_OFF = 7'b011_0010;

  typedef enum logic [4:0] {
    S_IDLE, S_WFI,
    S_ON_EN1, S_ON_SETTLE, S_ON_EN2, S_ON_PWAIT, S_ON_ISO, S_ON_L1,
    S_ON_L1WAIT, S_ON_MEMRDY, S_ON_SRAM, S_ON_CKISO, S_ON_CLK, S_ON_RST,
    S_OFF_ISO, S_OFF_CKISO, S_OFF_SRAM, S_OFF_L1, S_OFF_L1WAIT,
    S_OFF_RST, S_OFF_CLK, S_OFF_EN1, S_OFF_EN2, S_OFF_PWAIT
  } seq_state_e;

  typedef enum logic [1:0] {KIND_IDLE, KIND_STEP, KIND_DELAY, KIND_WAIT} seq_kind_e;

  typedef enum logic [2:0] {
    WS_NONE, WS_PWR_UP, WS_PWR_DOWN, WS_L1_SET, WS_L1_CLR, WS_CORE_IDLE
  } wait_src_e;

  typedef struct packed {
    logic       valid;
    logic       to_l1;
    logic [2:0] idx;
    logic       val;
  } line_op_t;

  function automatic seq_kind_e kind_of(seq_state_e s);
    case (s)
      S_IDLE:                                  return KIND_IDLE;
      S_ON_SETTLE, S_ON_MEMRDY:                return KIND_DELAY;
      S_WFI, S_ON_PWAIT, S_ON_L1WAIT,
      S_OFF_L1WAIT, S_OFF_PWAIT:               return KIND_WAIT;
      default:                                 return KIND_STEP;
    endcase
  endfunction

  function automatic seq_state_e next_of(seq_state_e s);
    case (s)
      S_WFI:        return S_OFF_ISO;
      S_ON_EN1:     return S_ON_SETTLE;
      S_ON_SETTLE:  return S_ON_EN2;
      S_ON_EN2:     return S_ON_PWAIT;
      S_ON_PWAIT:   return S_ON_ISO;
      S_ON_ISO:     return S_ON_L1;
      S_ON_L1:      return S_ON_L1WAIT;
      S_ON_L1WAIT:  return S_ON_MEMRDY;
      S_ON_MEMRDY:  return S_ON_SRAM;
      S_ON_SRAM:    return S_ON_CKISO;
      S_ON_CKISO:   return S_ON_CLK;
      S_ON_CLK:     return S_ON_RST;
      S_OFF_ISO:    return S_OFF_CKISO;
      S_OFF_CKISO:  return S_OFF_SRAM;
      S_OFF_SRAM:   return S_OFF_L1;
      S_OFF_L1:     return S_OFF_L1WAIT;
      S_OFF_L1WAIT: return S_OFF_RST;
      S_OFF_RST:    return S_OFF_CLK;
      S_OFF_CLK:    return S_OFF_EN1;
      S_OFF_EN1:    return S_OFF_EN2;
      S_OFF_EN2:    return S_OFF_PWAIT;
      default:      return S_IDLE;
    endcase
  endfunction

  function automatic line_op_t mk_op(logic to_l1, int idx, logic val);
    line_op_t o;
    o.valid = 1'b1;
    o.to_l1 = to_l1;
    o.idx   = 3'(idx);
    o.val   = val;
    return o;
  endfunction

  function automatic line_op_t op_of(seq_state_e s);
    case (s)
      S_ON_EN1:    return mk_op(1'b0, BIT_EN1,     1'b1);
      S_ON_EN2:    return mk_op(1'b0, BIT_EN2,     1'b1);
      S_ON_ISO:    return mk_op(1'b0, BIT_OUT_ISO, 1'b0);
      S_ON_L1:     return mk_op(1'b1, 0,           1'b0);
      S_ON_SRAM:   return mk_op(1'b0, BIT_SRAM_N,  1'b1);
      S_ON_CKISO:  return mk_op(1'b0, BIT_SCK_ISO, 1'b0);
      S_ON_CLK:    return mk_op(1'b0, BIT_CLK_DIS, 1'b0);
      S_ON_RST:    return mk_op(1'b0, BIT_RST_N,   1'b1);
      S_OFF_ISO:   return mk_op(1'b0, BIT_OUT_ISO, 1'b1);
      S_OFF_CKISO: return mk_op(1'b0, BIT_SCK_ISO, 1'b1);
      S_OFF_SRAM:  return mk_op(1'b0, BIT_SRAM_N,  1'b0);
      S_OFF_L1:    return mk_op(1'b1, 0,           1'b1);
      S_OFF_RST:   return mk_op(1'b0, BIT_RST_N,   1'b0);
      S_OFF_CLK:   return mk_op(1'b0, BIT_CLK_DIS, 1'b1);
      S_OFF_EN1:   return mk_op(1'b0, BIT_EN1,     1'b0);
      S_OFF_EN2:   return mk_op(1'b0, BIT_EN2,     1'b0);
      default:     return '0;
    endcase
  endfunction

  function automatic wait_src_e wait_of(seq_state_e s);
    case (s)
      S_WFI:        return WS_CORE_IDLE;
      S_ON_PWAIT:   return WS_PWR_UP;
      S_ON_L1WAIT:  return WS_L1_CLR;
      S_OFF_L1WAIT: return WS_L1_SET;
      S_OFF_PWAIT:  return WS_PWR_DOWN;
      default:      return WS_NONE;
    endcase
  endfunction

  // true on the last cycle of a window of 'limit' cycles counted from 0
  function automatic logic count_hit(int unsigned cnt, int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/cps_cycle_timer.sv
module cps_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cps_ack_match.sv
module cps_ack_match
  import cps_pkg::*;
(
  input  wait_src_e sel,
  input  logic      pwr_ack,
  input  logic      pwr_ack2,
  input  logic      l1_ack,
  input  logic      core_idle,
  output logic      met
);

  always_comb begin
    case (sel)
      WS_PWR_UP:    met = pwr_ack & pwr_ack2;
      WS_PWR_DOWN:  met = ~pwr_ack & ~pwr_ack2;
      WS_L1_SET:    met = l1_ack;
      WS_L1_CLR:    met = ~l1_ack;
      WS_CORE_IDLE: met = core_idle;
      default:      met = 1'b0;
    endcase
  end

endmodule

// File: rtl/cps_line_reg.sv
module cps_line_reg
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  line_op_t          op,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              l1_q
);

  for (genvar g = 0; g < CTRL_W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= CTRL_ALL_OFF[g];
      end else if (op.valid && !op.to_l1 && (op.idx == 3'(g))) begin
        ctrl_q[g] <= op.val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q <= 1'b1;
    end else if (op.valid && op.to_l1) begin
      l1_q <= op.val;
    end
  end

  // R2: second switch closes only behind the first
  a_r2_en2_after_en1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[BIT_EN2]) |-> ctrl_q[BIT_EN1]);

  // R3: memory wakes only after outputs are released with power on
  a_r3_l1_wake_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l1_q) |-> (!ctrl_q[BIT_OUT_ISO] && ctrl_q[BIT_EN2]));

  // R4: reset is released last
  a_r4_reset_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[BIT_RST_N]) |-> (!ctrl_q[BIT_CLK_DIS] && !ctrl_q[BIT_SCK_ISO]
                                  && ctrl_q[BIT_SRAM_N] && !l1_q));

  // R6: switch opens only with core held in reset and clock gated
  a_r6_en1_off_safe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[BIT_EN1]) |-> (!ctrl_q[BIT_RST_N] && ctrl_q[BIT_CLK_DIS]
                                && ctrl_q[BIT_OUT_ISO] && l1_q));

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int SETTLE_CYC  = 4,
  parameter int MEMRDY_CYC  = 3,
  parameter int TIMEOUT_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              off_wait_idle,
  input  logic              core_idle,
  input  logic              pwr_ack,
  input  logic              pwr_ack2,
  input  logic              l1_ack,
  output logic [CTRL_W-1:0] dom_ctrl,
  output logic              l1_pdn_req,
  output logic              seq_busy,
  output logic              seq_done,
  output logic              seq_fail
);

  localparam int LONG_A  = (SETTLE_CYC > MEMRDY_CYC) ? SETTLE_CYC : MEMRDY_CYC;
  localparam int LONGEST = (LONG_A > TIMEOUT_CYC) ? LONG_A : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  seq_state_e       state_q, state_d;
  seq_kind_e        kind;
  wait_src_e        wsel;
  line_op_t         op;
  logic [CNT_W-1:0] cnt;
  logic             cond_met;
  logic             restart;
  logic             ev_accept, ev_timeout, ev_finish;
  logic             delay_end;

  assign kind = kind_of(state_q);
  assign wsel = wait_of(state_q);
  assign op   = (kind == KIND_STEP) ? op_of(state_q) : '0;

  cps_ack_match u_match (
    .sel       (wsel),
    .pwr_ack   (pwr_ack),
    .pwr_ack2  (pwr_ack2),
    .l1_ack    (l1_ack),
    .core_idle (core_idle),
    .met       (cond_met)
  );

  cps_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt)
  );

  cps_line_reg u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .ctrl_q (dom_ctrl),
    .l1_q   (l1_pdn_req)
  );

  assign delay_end = (state_q == S_ON_SETTLE)
                   ? count_hit(32'(cnt), SETTLE_CYC)
                   : count_hit(32'(cnt), MEMRDY_CYC);

  always_comb begin
    state_d    = state_q;
    ev_accept  = 1'b0;
    ev_timeout = 1'b0;
    ev_finish  = 1'b0;
    case (kind)
      KIND_IDLE: begin
        if (req_on) begin
          state_d   = S_ON_EN1;
          ev_accept = 1'b1;
        end else if (req_off) begin
          state_d   = off_wait_idle ? S_WFI : S_OFF_ISO;
          ev_accept = 1'b1;
        end
      end
      KIND_STEP: begin
        state_d   = next_of(state_q);
        ev_finish = (state_q == S_ON_RST);
      end
      KIND_DELAY: begin
        if (delay_end) state_d = next_of(state_q);
      end
      default: begin
        // acknowledge checked first: it wins over an expiring bound
        if (cond_met) begin
          state_d   = next_of(state_q);
          ev_finish = (state_q == S_OFF_PWAIT);
        end else if (count_hit(32'(cnt), TIMEOUT_CYC)) begin
          state_d    = S_IDLE;
          ev_timeout = 1'b1;
        end
      end
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      seq_done <= 1'b0;
      seq_fail <= 1'b0;
    end else begin
      state_q  <= state_d;
      seq_done <= ev_finish;
      seq_fail <= ev_timeout;
    end
  end

  assign seq_busy = (state_q != S_IDLE);

  // R10: outcome pulses are exclusive
  a_r10_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, seq_fail}));

  // R10: busy drops only together with an outcome pulse
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> (seq_done || seq_fail));

  // R7: a wait never outlives its bound
  a_r7_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_WAIT) |-> (32'(cnt) < TIMEOUT_CYC));

  // R9: an idle-wait abort touches no line
  a_r9_idle_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WFI && ev_timeout) |=> ($stable(dom_ctrl) && $stable(l1_pdn_req)));

  // R11: lines hold still whenever the sequencer is idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |=> $stable(dom_ctrl));

  // R12: simultaneous requests resolve to power-up
  a_r12_on_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req_on) |=> (state_q == S_ON_EN1));

endmodule

// File: tb/core_pwr_seq_bench.sv
`timescale 1ns/1ps
module core_pwr_seq_bench;

  localparam int T = 10;
  localparam int S = 4;
  localparam int M = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_on = 1'b0, req_off = 1'b0, off_wait_idle = 1'b0, core_idle = 1'b0;
  logic       pwr_ack, pwr_ack2, l1_ack;
  logic [6:0] dom_ctrl;
  logic       l1_pdn_req, seq_busy, seq_done, seq_fail;

  int errors = 0;
  int checks = 0;
  int tick = 0;
  int d2 = 0;
  int dl = 0;

  always #2 clk = ~clk;

  core_pwr_seq #(.SETTLE_CYC(S), .MEMRDY_CYC(M), .TIMEOUT_CYC(T)) u_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .off_wait_idle(off_wait_idle), .core_idle(core_idle),
    .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .l1_ack(l1_ack),
    .dom_ctrl(dom_ctrl), .l1_pdn_req(l1_pdn_req),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_fail(seq_fail)
  );

  // switch and memory stand-ins: ack follows its request after d edges
  logic [31:0] sr2, srl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr2 <= '0;
      srl <= '1;
    end else begin
      sr2 <= {sr2[30:0], dom_ctrl[3]};
      srl <= {srl[30:0], l1_pdn_req};
    end
  end
  assign pwr_ack  = dom_ctrl[2];
  assign pwr_ack2 = (d2 == 0) ? dom_ctrl[3] : sr2[d2-1];
  assign l1_ack   = (dl == 0) ? l1_pdn_req  : srl[dl-1];

  // change stamps
  int t_bit[7];
  int t_l1, t_a2, t_al;
  logic [6:0] p_ctrl;
  logic p_l1, p_a2, p_al;
  always @(posedge clk) tick++;
  always @(negedge clk) begin
    for (int i = 0; i < 7; i++) if (dom_ctrl[i] !== p_ctrl[i]) t_bit[i] = tick;
    if (l1_pdn_req !== p_l1) t_l1 = tick;
    if (pwr_ack2 !== p_a2) t_a2 = tick;
    if (l1_ack !== p_al) t_al = tick;
    p_ctrl = dom_ctrl; p_l1 = l1_pdn_req; p_a2 = pwr_ack2; p_al = l1_ack;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pause(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic run_seq(input bit on, input bit off, input bit wfi, input bit inject,
                         output bit got_done, output bit got_fail);
    int n;
    bit busy_bad;
    @(negedge clk); req_on = on; req_off = off; off_wait_idle = wfi;
    @(negedge clk); req_on = 1'b0; req_off = 1'b0; off_wait_idle = 1'b0;
    n = 0; busy_bad = 1'b0;
    while (!seq_done && !seq_fail && n < 400) begin
      if (!seq_busy) busy_bad = 1'b1;
      if (inject) begin req_on = (n == 3); req_off = (n == 3); end
      @(negedge clk); n++;
    end
    req_on = 1'b0; req_off = 1'b0;
    if (n >= 400) chk(1'b0, "R10 sequence never ended", n, 0);
    got_done = seq_done; got_fail = seq_fail;
    chk(!busy_bad, "R10 busy held through sequence", int'(busy_bad), 0);
    chk(!seq_busy, "R10 busy low on end pulse", int'(seq_busy), 0);
    @(negedge clk);
    chk(!seq_done && !seq_fail, "R10 end pulse one cycle", int'({seq_done, seq_fail}), 0);
  endtask

  task automatic expect_word(input string tag, input logic [6:0] w, input logic l1);
    chk(dom_ctrl === w, tag, int'(dom_ctrl), int'(w));
    chk(l1_pdn_req === l1, tag, int'(l1_pdn_req), int'(l1));
  endtask

  task automatic go_on(input string tag);
    bit dn, fl;
    run_seq(1'b1, 1'b0, 1'b0, 1'b0, dn, fl);
    chk(dn && !fl, tag, int'(dn), 1);
    expect_word(tag, 7'h4D, 1'b0);
    pause(40);
  endtask

  task automatic go_off(input string tag);
    bit dn, fl;
    run_seq(1'b0, 1'b1, 1'b0, 1'b0, dn, fl);
    chk(dn && !fl, tag, int'(dn), 1);
    expect_word(tag, 7'h32, 1'b1);
    pause(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit dn, fl;
    pause(3);
    // R1 reset state
    chk(dom_ctrl === 7'h32, "R1 reset word", int'(dom_ctrl), 'h32);
    chk(l1_pdn_req === 1'b1, "R1 reset l1 request", int'(l1_pdn_req), 1);
    chk(!seq_busy && !seq_done && !seq_fail, "R1 reset status",
        int'({seq_busy, seq_done, seq_fail}), 0);
    rst_n = 1'b1;
    pause(40);

    // R2 R3 R4 nominal power-up with ordering
    go_on("R4 power-up final word");
    chk(t_bit[3] > t_bit[2], "R2 en2 after en1", t_bit[3], t_bit[2] + 1);
    chk(t_bit[3] - t_bit[2] >= S, "R2 settle interval", t_bit[3] - t_bit[2], S);
    chk(t_bit[1] > t_a2 && t_bit[1] > t_bit[3], "R2 isolation kept until acks", t_bit[1], t_a2 + 1);
    chk(t_l1 > t_bit[1], "R3 l1 release after isolation", t_l1, t_bit[1] + 1);
    chk(t_bit[6] > t_al, "R3 sram waits l1 ack low", t_bit[6], t_al + 1);
    chk(t_bit[6] - t_al >= M, "R4 memory-ready interval", t_bit[6] - t_al, M);
    chk(t_bit[5] > t_bit[6] && t_bit[4] > t_bit[5] && t_bit[0] > t_bit[4],
        "R4 sram clock reset order", t_bit[0], t_bit[4] + 1);

    // R5 R6 nominal power-down with ordering
    go_off("R6 power-down final word");
    chk(t_bit[5] > t_bit[1] && t_bit[6] > t_bit[5], "R5 isolate order", t_bit[6], t_bit[5] + 1);
    chk(t_l1 > t_bit[6], "R5 l1 request after sram", t_l1, t_bit[6] + 1);
    chk(t_bit[0] > t_al, "R6 reset after l1 ack", t_bit[0], t_al + 1);
    chk(t_bit[4] > t_bit[0] && t_bit[2] > t_bit[4] && t_bit[3] > t_bit[2],
        "R6 reset clock switch order", t_bit[3], t_bit[2] + 1);

    // R7 R8 R13 sweep of the secondary power ack delay
    for (int d = 0; d <= T + 2; d++) begin
      d2 = d; pause(40);
      run_seq(1'b1, 1'b0, 1'b0, 1'b0, dn, fl);
      if (d <= T - 1) begin
        chk(dn && !fl, (d == T - 1) ? "R8 ack on last edge wins (up)" : "R7 power ack in time",
            int'(dn), 1);
        expect_word("R7 up word", 7'h4D, 1'b0);
        pause(40);
        run_seq(1'b0, 1'b1, 1'b0, 1'b0, dn, fl);
        chk(dn && !fl, (d == T - 1) ? "R8 ack on last edge wins (down)" : "R7 power-down ack",
            int'(dn), 1);
        expect_word("R7 down word", 7'h32, 1'b1);
      end else begin
        chk(fl && !dn, "R7 power ack timeout", int'(fl), 1);
        expect_word("R7 frozen at power wait", 7'h3E, 1'b1);
        d2 = 0; pause(40);
        go_off("R13 recover after power fail");
      end
      d2 = 0; pause(40);
    end

    // R7 R8 R13 sweep of the L1 ack delay, both directions
    for (int d = 0; d <= T + 2; d++) begin
      dl = 0; pause(40);
      go_on("R7 l1 sweep power-up");
      dl = d; pause(40);
      run_seq(1'b0, 1'b1, 1'b0, 1'b0, dn, fl);
      if (d <= T - 1) begin
        chk(dn && !fl, (d == T - 1) ? "R8 l1 ack on last edge (down)" : "R7 l1 ack down", int'(dn), 1);
        expect_word("R7 l1 down word", 7'h32, 1'b1);
      end else begin
        chk(fl && !dn, "R7 l1 set timeout", int'(fl), 1);
        expect_word("R7 frozen at l1 set wait", 7'h2F, 1'b1);
        dl = 0; pause(40);
        go_off("R13 recover after l1 set fail");
      end
      dl = d; pause(40);
      run_seq(1'b1, 1'b0, 1'b0, 1'b0, dn, fl);
      if (d <= T - 1) begin
        chk(dn && !fl, (d == T - 1) ? "R8 l1 ack on last edge (up)" : "R7 l1 ack up", int'(dn), 1);
        expect_word("R7 l1 up word", 7'h4D, 1'b0);
      end else begin
        chk(fl && !dn, "R7 l1 clear timeout", int'(fl), 1);
        expect_word("R7 frozen at l1 clear wait", 7'h3C, 1'b0);
      end
      dl = 0; pause(40);
      go_off("R13 return to off");
    end

    // R9 idle-gated power-down
    go_on("R9 setup");
    core_idle = 1'b0;
    run_seq(1'b0, 1'b1, 1'b1, 1'b0, dn, fl);
    chk(fl && !dn, "R9 no idle gives fail", int'(fl), 1);
    expect_word("R9 lines untouched", 7'h4D, 1'b0);
    core_idle = 1'b1;
    run_seq(1'b0, 1'b1, 1'b1, 1'b0, dn, fl);
    chk(dn && !fl, "R9 idle seen proceeds", int'(dn), 1);
    expect_word("R9 off word", 7'h32, 1'b1);
    core_idle = 1'b0;
    pause(40);

    // R11 requests during a sequence are ignored
    run_seq(1'b1, 1'b0, 1'b0, 1'b1, dn, fl);
    chk(dn && !fl, "R11 sequence unaffected", int'(dn), 1);
    pause(20);
    chk(!seq_busy, "R11 no follow-on sequence", int'(seq_busy), 0);
    expect_word("R11 word kept", 7'h4D, 1'b0);
    go_off("R11 back off");

    // R12 both requests together
    run_seq(1'b1, 1'b1, 1'b0, 1'b0, dn, fl);
    chk(dn && !fl, "R12 both requests", int'(dn), 1);
    expect_word("R12 power-up chosen", 7'h4D, 1'b0);
    pause(40);
    go_off("R12 back off");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule